// File: doc/BRIEF.md
# Burst Address Counter with Bypass

This block generates the address for a clocked memory array. A registered counter holds the burst address. On each rising clock edge it is cleared, loaded from the external address bus, incremented, or held. The choice follows a fixed priority: clear first, then load, then increment. The counter runs whether or not the memory is selected, so chip-enable logic is kept outside it.

The address sent to the array is chosen combinationally, so an access never waits a cycle. In a clear cycle the array sees zero. In a load cycle it sees the external bus directly. In every other cycle it sees the counter. Holding the load strobe low on every cycle therefore gives fully random addressing, and releasing it gives a sequential burst that starts from the last loaded value. When the counter increments past all ones, it wraps to zero.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low the counter output `cnt_o` is 0, whatever the other inputs do.
- R2: If `clr_ni` is low at a rising edge, `cnt_o` becomes 0 after that edge, regardless of `ld_ni` and `inc_ni`.
- R3: If `clr_ni` is high and `ld_ni` is low at a rising edge, `cnt_o` takes the value of `addr_i` after that edge.
- R4: If `clr_ni` and `ld_ni` are high and `inc_ni` is low at a rising edge, `cnt_o` increases by one.
- R5: An increment from the all-ones value gives 0.
- R6: If `clr_ni`, `ld_ni` and `inc_ni` are all high at a rising edge, `cnt_o` keeps its value and `addr_i` has no effect.
- R7: While `clr_ni` is high and `ld_ni` is low, `addr_o` equals `addr_i` in the same cycle.
- R8: While `clr_ni` and `ld_ni` are both high, `addr_o` equals `cnt_o`.
- R9: While `clr_ni` is low, `addr_o` is 0 in the same cycle, so an access coincident with a clear goes to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address bus |
| ld_ni | input | 1 | Load strobe, active low |
| inc_ni | input | 1 | Count enable, active low |
| clr_ni | input | 1 | Synchronous counter clear, active low |
| addr_o | output | ADDR_W | Address presented to the array |
| cnt_o | output | ADDR_W | Registered counter value |

## Verification
The assertions assume that the strobe, count-enable and clear inputs are known (not X) and are stable around each rising edge. The bench meets this by changing every input only on the falling edge. The combinational address checks sample shortly after that change, and the counter checks sample half a cycle after the edge that updates it. Directed phases cover each priority collision, the wrap from all ones, and hold with a moving bus. A long random phase then weights the control lines so that every mode occurs often.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/burst_op_dec.sv
module burst_op_dec
  import burst_addr_pkg::*;
(
  input  logic    clr_ni,
  input  logic    ld_ni,
  input  logic    inc_ni,
  output cnt_op_e op_o
);
  // fixed priority: clear > load > increment > hold
  always_comb begin
    if (!clr_ni)      op_o = OP_CLEAR;
    else if (!ld_ni)  op_o = OP_LOAD;
    else if (!inc_ni) op_o = OP_INC;
    else              op_o = OP_HOLD;
  end
endmodule

// File: rtl/burst_cnt_reg.sv
module burst_cnt_reg
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cnt_op_e           op_i,
  input  logic [ADDR_W-1:0] load_val_i,
  output logic [ADDR_W-1:0] cnt_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ALL1 = '1;

  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (op_i)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = load_val_i;
      OP_INC:   cnt_d = cnt_q + STEP;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CLEAR |=> cnt_q == '0); // R2
  AST_LOAD_TAKES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> cnt_q == $past(load_val_i)); // R3
  AST_INC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_INC |=> cnt_q == $past(cnt_q) + STEP); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC && cnt_q == ALL1) |=> cnt_q == '0); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/burst_addr_mux.sv
module burst_addr_mux
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  cnt_op_e           op_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [ADDR_W-1:0] cnt_i,
  output logic [ADDR_W-1:0] addr_o
);
  // bypass: clear and load are visible in the same cycle
  always_comb begin
    unique case (op_i)
      OP_CLEAR: addr_o = '0;
      OP_LOAD:  addr_o = ext_addr_i;
      default:  addr_o = cnt_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_ni,
  input  logic              inc_ni,
  input  logic              clr_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] cnt_o
);
  cnt_op_e op;

  burst_op_dec u_dec (
    .clr_ni (clr_ni),
    .ld_ni  (ld_ni),
    .inc_ni (inc_ni),
    .op_o   (op)
  );

  burst_cnt_reg #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (addr_i),
    .cnt_o      (cnt_o)
  );

  burst_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .op_i       (op),
    .ext_addr_i (addr_i),
    .cnt_i      (cnt_o),
    .addr_o     (addr_o)
  );

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (cnt_o == '0); // R1
  end

  AST_BYPASS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !ld_ni) |-> addr_o == addr_i); // R7
  AST_COUNTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && ld_ni) |-> addr_o == cnt_o); // R8
  AST_CLEAR_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> addr_o == '0); // R9
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 8;
  localparam int MASK = (1 << AW) - 1;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          rst_ni, ld_ni, inc_ni, clr_ni;
  logic [AW-1:0] addr_i, addr_o, cnt_o;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .ld_ni  (ld_ni),
    .inc_ni (inc_ni),
    .clr_ni (clr_ni),
    .addr_o (addr_o),
    .cnt_o  (cnt_o)
  );

  int    errs = 0;
  int    checks = 0;
  int    ref_cnt = 0;
  string cnt_tag = "R1";
  bit    done = 0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check, then model the rising edge
  task automatic step(input logic c, input logic l, input logic i, input int a);
    int exp_addr;
    string atag;
    @(negedge clk_i);
    clr_ni = c; ld_ni = l; inc_ni = i; addr_i = AW'(a);
    #1;
    chk(int'(cnt_o), ref_cnt, cnt_tag);
    if (!c)      begin exp_addr = 0;       atag = "R9"; end
    else if (!l) begin exp_addr = a & MASK; atag = "R7"; end
    else         begin exp_addr = ref_cnt; atag = "R8"; end
    chk(int'(addr_o), exp_addr, atag);
    @(posedge clk_i);
    if (!c)      begin ref_cnt = 0;        cnt_tag = "R2"; end
    else if (!l) begin ref_cnt = a & MASK; cnt_tag = "R3"; end
    else if (!i) begin
      cnt_tag = (ref_cnt == MASK) ? "R5" : "R4";
      ref_cnt = (ref_cnt + 1) & MASK;
    end
    else cnt_tag = "R6";
  endtask

  initial begin
    rst_ni = 1'b0; clr_ni = 1'b1; ld_ni = 1'b0; inc_ni = 1'b0; addr_i = 8'h55;
    #1 chk(int'(cnt_o), 0, "R1");
    @(posedge clk_i); #1;
    chk(int'(cnt_o), 0, "R1");
    @(negedge clk_i); rst_ni = 1'b1; ld_ni = 1'b1; inc_ni = 1'b1;

    step(1, 0, 1, 8'h3a);               // load, R3 / R7
    step(1, 1, 0, 8'h00);               // R4
    step(1, 1, 0, 8'hff);               // R4
    step(1, 1, 1, 8'h11);               // hold with moving bus, R6
    step(1, 1, 1, 8'hc4);               // R6
    step(1, 0, 0, 8'h90);               // load outranks increment
    step(0, 0, 0, 8'h77);               // clear outranks load, R2 / R9
    step(1, 1, 1, 8'h77);
    step(1, 0, 1, 8'hfe);
    step(1, 1, 0, 8'h00);               // to ff
    step(1, 1, 0, 8'h00);               // wrap, R5
    step(0, 1, 0, 8'h00);               // clear vs increment
    step(1, 1, 1, 8'h00);
    for (int k = 0; k < 20; k++) step(1, 0, 1, (k * 37 + 5));  // random addressing
    for (int k = 0; k < 2000; k++) begin
      int r = $urandom_range(0, 9);
      step(r != 0, r > 3 ? 1'b1 : 1'b0, r > 6 ? 1'b1 : 1'b0, int'($urandom_range(0, MASK)));
    end
    step(1, 1, 1, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule